// File: doc/BRIEF.md
# Count/Compare Timer With Interrupt Routing

This block keeps a 32-bit up-counter and a 32-bit threshold register for a processor's timer function. Each cycle that the tick-enable input is high and counting is not frozen, the counter advances by one and wraps modulo 2^32. When an advance brings the counter onto the threshold value, the block raises a timer request. That request appears on one line of an 8-line interrupt vector. A 3-bit select field chooses the line. When the design is built with the newer revision option, the request also sets a pending flag.

Software loads the counter and the threshold through two write strobes, and reads the counter on a read port. A write to the threshold register acknowledges the request: it drops the interrupt line and clears the pending flag. A freeze input stops the counter and suppresses any new match. Reset puts the threshold at 0 and the counter at 1.

Top module: `cp_timer`

## Requirements
- R1: After reset, the counter reads 1, all eight interrupt lines are low, the pending flag is low, and the threshold holds 0. A counter load of 0xFFFFFFFF followed by one tick therefore raises a request.
- R2: Each cycle with tick_i high, halt_i low and no counter write, the counter increases by one. The new value is visible right after that clock edge, and the counter wraps from 0xFFFFFFFF to 0.
- R3: While halt_i is high, the counter holds its value whatever tick_i does, and no new request is raised.
- R4: A counter write loads cnt_wdata_i at the next edge and takes priority over a tick in the same cycle. A load whose value equals the threshold does not raise a request.
- R5: When an increment makes the counter equal the threshold, the selected line goes high after that same edge. With REV2=1, pend_o also goes high. Both stay high, across further ticks and counter writes, until a threshold write or reset.
- R6: A threshold write drops the interrupt line and clears pend_o at the next edge. In a cycle where a match and a threshold write coincide, the write wins and no request is left raised.
- R7: While a request is raised, irq_o is one-hot, with bit line_sel_i set. The bit follows line_sel_i in the same cycle. With no request, irq_o is 0.
- R8: With REV2=0, pend_o stays 0 at all times, while the line output still behaves as in R5 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle counting enable |
| halt_i | input | 1 | Freeze counter and suppress matches |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 32 | Counter write value |
| cmp_wr_i | input | 1 | Threshold write strobe (acknowledges request) |
| cmp_wdata_i | input | 32 | Threshold write value |
| line_sel_i | input | 3 | Interrupt line index |
| cnt_o | output | 32 | Counter read value |
| irq_o | output | 8 | Interrupt line vector |
| pend_o | output | 1 | Timer request pending flag |

## Verification
A match and an acknowledgement can land in the same cycle: the tick that carries the counter onto the threshold can coincide with a threshold write. The bench provokes this by parking the counter one below the threshold, then asserting tick_i and cmp_wr_i together. It expects the counter to advance, irq_o and pend_o to stay low, and a later match against the newly written threshold to fire normally. A second collision, a counter load together with a tick, is judged by the loaded value winning.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Package tmr_pkg
// Shared widths and the counter update code for the count/compare timer.
// Assumes: a single clock domain; all users import these constants.
package tmr_pkg;
    localparam int unsigned TMR_CNT_W = 32;
    localparam int unsigned TMR_SEL_W = 3;

    // Action taken on the counter in a given cycle
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_INC  = 2'd2
    } cnt_op_e;
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
// Module tmr_counter
// Free-running up-counter with load and freeze. Reports when an increment
// takes place and the value the counter is about to take.
// Assumes: a load has priority over an increment; wrap is modulo 2^CNT_W.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int unsigned     CNT_W   = TMR_CNT_W,
    parameter logic [CNT_W-1:0] RST_VAL = CNT_W'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             halt_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             inc_o,
    output logic [CNT_W-1:0] cnt_inc_o
);
    cnt_op_e          op;
    logic [CNT_W-1:0] cnt_q;

    // Decide this cycle's counter action by priority
    always_comb begin
        if (wr_i)                op = CNT_LOAD;
        else if (tick_i && !halt_i) op = CNT_INC;
        else                     op = CNT_HOLD;
    end

    assign cnt_inc_o = cnt_q + CNT_W'(1);
    assign inc_o     = (op == CNT_INC);

    // Update the counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else begin
            case (op)
                CNT_LOAD: cnt_q <= wdata_i;
                CNT_INC:  cnt_q <= cnt_inc_o;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_match.sv
`timescale 1ns/1ps
// Module tmr_match
// Holds the threshold register, detects an increment that lands on it and
// keeps the raised request and (optionally) the pending flag.
// Assumes: a threshold write in the same cycle as a match wins and clears.
module tmr_match #(
    parameter int unsigned CNT_W = tmr_pkg::TMR_CNT_W,
    parameter bit          REV2  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] cnt_inc_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             raised_o,
    output logic             pend_o
);
    logic [CNT_W-1:0] cmp_q;
    logic             raised_q;
    logic             hit;

    // An increment is about to make the counter equal the threshold
    assign hit = inc_i && (cnt_inc_i == cmp_q);

    // Threshold register, loaded by software writes
    always_ff @(posedge clk) begin
        if (!rst_n)        cmp_q <= '0;
        else if (cmp_wr_i) cmp_q <= cmp_wdata_i;
    end

    // Raised request: set by a hit, cleared by a threshold write
    always_ff @(posedge clk) begin
        if (!rst_n)        raised_q <= 1'b0;
        else if (cmp_wr_i) raised_q <= 1'b0;
        else if (hit)      raised_q <= 1'b1;
    end

    generate
        if (REV2) begin : g_pend
            logic pend_q;
            // Pending flag kept only for the newer revision
            always_ff @(posedge clk) begin
                if (!rst_n)        pend_q <= 1'b0;
                else if (cmp_wr_i) pend_q <= 1'b0;
                else if (hit)      pend_q <= 1'b1;
            end
            assign pend_o = pend_q;
        end else begin : g_no_pend
            assign pend_o = 1'b0;
        end
    endgenerate

    assign cmp_o    = cmp_q;
    assign raised_o = raised_q;
endmodule

// File: rtl/tmr_route.sv
`timescale 1ns/1ps
// Module tmr_route
// Steers the raised request onto one of 2^SEL_W interrupt lines.
// Assumes: the selection is applied combinationally, without a register.
module tmr_route #(
    parameter int unsigned SEL_W = tmr_pkg::TMR_SEL_W,
    localparam int unsigned NLINES = 1 << SEL_W
) (
    input  logic              raised_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [NLINES-1:0] irq_o
);
    genvar k;
    generate
        for (k = 0; k < NLINES; k++) begin : g_line
            // Drive line k when it is the selected one
            assign irq_o[k] = raised_i && (sel_i == SEL_W'(k));
        end
    endgenerate
endmodule

// File: rtl/cp_timer.sv
`timescale 1ns/1ps
// Module cp_timer
// Count/compare timer: counter, threshold match and interrupt line routing.
// Assumes: tick_i is a one-cycle enable in the clk domain; software writes
// arrive as single-cycle strobes.
module cp_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = TMR_CNT_W,
    parameter int unsigned SEL_W = TMR_SEL_W,
    parameter bit          REV2  = 1'b1,
    localparam int unsigned NLINES = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              halt_i,
    input  logic              cnt_wr_i,
    input  logic [CNT_W-1:0]  cnt_wdata_i,
    input  logic              cmp_wr_i,
    input  logic [CNT_W-1:0]  cmp_wdata_i,
    input  logic [SEL_W-1:0]  line_sel_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [NLINES-1:0] irq_o,
    output logic              pend_o
);
    logic             inc;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cmp_val;
    logic             raised;

    tmr_counter #(.CNT_W(CNT_W), .RST_VAL(CNT_W'(1))) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .halt_i    (halt_i),
        .wr_i      (cnt_wr_i),
        .wdata_i   (cnt_wdata_i),
        .cnt_o     (cnt_o),
        .inc_o     (inc),
        .cnt_inc_o (cnt_inc)
    );

    tmr_match #(.CNT_W(CNT_W), .REV2(REV2)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_i       (inc),
        .cnt_inc_i   (cnt_inc),
        .cmp_wr_i    (cmp_wr_i),
        .cmp_wdata_i (cmp_wdata_i),
        .cmp_o       (cmp_val),
        .raised_o    (raised),
        .pend_o      (pend_o)
    );

    tmr_route #(.SEL_W(SEL_W)) u_route (
        .raised_i (raised),
        .sel_i    (line_sel_i),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
// Module tmr_checker
// Temporal properties of the count/compare timer, bound into cp_timer.
// Assumes: observes ports plus the threshold register value.
module tmr_checker #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned SEL_W = 3,
    parameter bit          REV2  = 1'b1,
    localparam int unsigned NLINES = 1 << SEL_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              halt_i,
    input logic              cnt_wr_i,
    input logic [CNT_W-1:0]  cnt_wdata_i,
    input logic              cmp_wr_i,
    input logic [CNT_W-1:0]  cmp_wdata_i,
    input logic [SEL_W-1:0]  line_sel_i,
    input logic [CNT_W-1:0]  cmp_val,
    input logic [CNT_W-1:0]  cnt_o,
    input logic [NLINES-1:0] irq_o,
    input logic              pend_o
);
    // R2: a tick without freeze or load advances by one
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !halt_i && !cnt_wr_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

    // R3: frozen counter holds its value
    a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !cnt_wr_i) |=> $stable(cnt_o));

    // R4: a load takes the written value
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> (cnt_o == $past(cnt_wdata_i)));

    // R5: an increment landing on the threshold raises a line
    a_r5_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !halt_i && !cnt_wr_i && !cmp_wr_i &&
         (cnt_o + CNT_W'(1) == cmp_val)) |=> (irq_o != '0) && (pend_o || !REV2));

    // R6: a threshold write drops every line and the pending flag
    a_r6_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr_i |=> (irq_o == '0) && !pend_o);

    // R7: never more than one line active
    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    // R8: pending flag follows the line request in the newer revision only
    a_r8_pend_line: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> (irq_o != '0));

    logic unused_ok;
    assign unused_ok = ^{cmp_wdata_i, line_sel_i};
endmodule

bind cp_timer tmr_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W), .REV2(REV2)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .halt_i      (halt_i),
    .cnt_wr_i    (cnt_wr_i),
    .cnt_wdata_i (cnt_wdata_i),
    .cmp_wr_i    (cmp_wr_i),
    .cmp_wdata_i (cmp_wdata_i),
    .line_sel_i  (line_sel_i),
    .cmp_val     (cmp_val),
    .cnt_o       (cnt_o),
    .irq_o       (irq_o),
    .pend_o      (pend_o)
);

// File: tb/test_cp_timer.sv
`timescale 1ns/1ps
// Directed bench for cp_timer: one task per scenario, each checking itself.
module test_cp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        halt_i = 1'b0;
    logic        cnt_wr_i = 1'b0;
    logic [31:0] cnt_wdata_i = '0;
    logic        cmp_wr_i = 1'b0;
    logic [31:0] cmp_wdata_i = '0;
    logic [2:0]  line_sel_i = '0;
    logic [31:0] cnt_o, cnt1;
    logic [7:0]  irq_o, irq1;
    logic        pend_o, pend1;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cp_timer i_cp_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .halt_i(halt_i),
        .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
        .cmp_wr_i(cmp_wr_i), .cmp_wdata_i(cmp_wdata_i),
        .line_sel_i(line_sel_i), .cnt_o(cnt_o), .irq_o(irq_o), .pend_o(pend_o)
    );

    cp_timer #(.REV2(1'b0)) i_cp_timer_v1 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .halt_i(halt_i),
        .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
        .cmp_wr_i(cmp_wr_i), .cmp_wdata_i(cmp_wdata_i),
        .line_sel_i(line_sel_i), .cnt_o(cnt1), .irq_o(irq1), .pend_o(pend1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr_cnt(input logic [31:0] v);
        cnt_wr_i = 1'b1; cnt_wdata_i = v; cyc(1); cnt_wr_i = 1'b0;
    endtask

    task automatic wr_cmp(input logic [31:0] v);
        cmp_wr_i = 1'b1; cmp_wdata_i = v; cyc(1); cmp_wr_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1; cyc(n); tick_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 count", cnt_o, 32'd1);
        check("R1 lines", {24'd0, irq_o}, 32'd0);
        check("R1 pend", {31'd0, pend_o}, 32'd0);
        wr_cnt(32'hFFFF_FFFF);
        ticks(1);
        check("R2 wrap", cnt_o, 32'd0);
        check("R1 thr0 line", {24'd0, irq_o}, 32'h01);
        check("R5 pend", {31'd0, pend_o}, 32'd1);
        check("R8 v1 line", {24'd0, irq1}, 32'h01);
        check("R8 v1 pend", {31'd0, pend1}, 32'd0);
    endtask

    task automatic t_count;
        wr_cmp(32'd1000);
        check("R6 ack line", {24'd0, irq_o}, 32'd0);
        check("R6 ack pend", {31'd0, pend_o}, 32'd0);
        wr_cnt(32'd10);
        ticks(5);
        check("R2 five", cnt_o, 32'd15);
        cyc(3);
        check("R2 idle", cnt_o, 32'd15);
        ticks(2);
        check("R2 gap", cnt_o, 32'd17);
    endtask

    task automatic t_match;
        wr_cmp(32'd100);
        wr_cnt(32'd97);
        ticks(2);
        check("R5 before", {24'd0, irq_o}, 32'd0);
        ticks(1);
        check("R5 count", cnt_o, 32'd100);
        check("R5 line", {24'd0, irq_o}, 32'h01);
        check("R5 pend", {31'd0, pend_o}, 32'd1);
        ticks(4);
        wr_cnt(32'd5);
        check("R5 sticky", {24'd0, irq_o}, 32'h01);
        line_sel_i = 3'd5; #1;
        check("R7 sel5", {24'd0, irq_o}, 32'h20);
        line_sel_i = 3'd7; #1;
        check("R7 sel7", {24'd0, irq_o}, 32'h80);
        wr_cmp(32'd40);
        check("R6 line", {24'd0, irq_o}, 32'd0);
        check("R6 pend", {31'd0, pend_o}, 32'd0);
        line_sel_i = 3'd0;
    endtask

    task automatic t_halt;
        wr_cmp(32'd10);
        wr_cnt(32'd9);
        halt_i = 1'b1;
        ticks(6);
        check("R3 hold", cnt_o, 32'd9);
        check("R3 no irq", {24'd0, irq_o}, 32'd0);
        halt_i = 1'b0;
        line_sel_i = 3'd2;
        ticks(1);
        check("R3 resume", cnt_o, 32'd10);
        check("R7 sel2", {24'd0, irq_o}, 32'h04);
        wr_cmp(32'd0);
        line_sel_i = 3'd0;
    endtask

    task automatic t_load;
        wr_cmp(32'd50);
        wr_cnt(32'd50);
        check("R4 load", cnt_o, 32'd50);
        check("R4 no irq", {24'd0, irq_o}, 32'd0);
        tick_i = 1'b1; cnt_wr_i = 1'b1; cnt_wdata_i = 32'd49;
        cyc(1);
        cnt_wr_i = 1'b0; tick_i = 1'b0;
        check("R4 prio", cnt_o, 32'd49);
        check("R4 prio irq", {24'd0, irq_o}, 32'd0);
    endtask

    task automatic t_race;
        wr_cmp(32'd20);
        wr_cnt(32'd19);
        tick_i = 1'b1; cmp_wr_i = 1'b1; cmp_wdata_i = 32'd30;
        cyc(1);
        tick_i = 1'b0; cmp_wr_i = 1'b0;
        check("R6 race count", cnt_o, 32'd20);
        check("R6 race line", {24'd0, irq_o}, 32'd0);
        check("R6 race pend", {31'd0, pend_o}, 32'd0);
        ticks(9);
        check("R6 race before", {24'd0, irq_o}, 32'd0);
        ticks(1);
        check("R6 new thr", {24'd0, irq_o}, 32'h01);
        check("R8 v1 pend", {31'd0, pend1}, 32'd0);
        check("R8 v1 line", {24'd0, irq1}, 32'h01);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_count();
        t_match();
        t_halt();
        t_load();
        t_race();
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            finish_run();
        end
    end
endmodule